// File: doc/BRIEF.md
# Programmable-Tap Pseudo-Noise Generator

This block is a 40-bit linear feedback shift register that generates a pseudo-noise bit stream. The feedback taps come from a fully programmable 40-bit mask. On every enabled step the block masks the current state with the tap mask and takes the parity of the result. It then folds in a one-bit carry input, shifts the state one place toward its most significant end, and writes the new bit into bit 0. The bit that leaves the top of the state is lost.

While the carry input is held low, the block runs free as a sequence generator. To scramble a serial data stream, present one data bit on the carry input before each step. The scrambled bit then shows up on the serial output after that step.

A packer counts the steps. After every 32 steps it presents the low 32 bits of the state as one word and raises a strobe for a single cycle. A seed load or a tap-mask load restarts that count.

Top module: `pn_gen`

## Requirements
- R1: While reset is low and after it is released, the state equals the seed parameter (default 0x00_00000001) and the mask equals the mask parameter (default 0x8D_AB181CD4). `word_out` is 0, `word_valid` is 0, and `bit_out` equals bit 0 of the reset seed.
- R2: A step with no load computes feedback = XOR-reduce(state AND mask) XOR `carry_in`, using the state before the shift. The new state is {state[38:0], feedback}, so the old bit 39 is dropped. `bit_out` always shows state bit 0.
- R3: When `step_en` is low and no load is requested, the state does not change and no word is emitted.
- R4: `word_valid` goes high for exactly one cycle after the clock edge that performs the 32nd step since the last load or the last emitted word. It is low at every other step.
- R5: From seed 0x00_00000001 and mask 0x8D_AB181CD4, with `carry_in` held at 0, the first four emitted words are 0x2FC95ADF, 0x5520BD91, 0x7FEF80D5 and 0x915C34D1.
- R6: In a cycle where `seed_load` is high, the state takes `seed_value`, any step requested in that cycle is discarded, and the step count restarts from zero.
- R7: `mask_load` replaces the mask, leaves the state unchanged, takes priority over a step in the same cycle, and restarts the step count. The seed and the mask can both be loaded in one cycle.
- R8: `word_out` keeps its value from one strobe to the next.
- R9: With the mask all zero, each feedback bit equals `carry_in`. After 32 steps the word therefore holds the input bits with the first one in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load `seed_value` into the state |
| seed_value | input | 40 | Seed for the state register |
| mask_load | input | 1 | Load `mask_value` into the tap mask |
| mask_value | input | 40 | Tap mask |
| step_en | input | 1 | Perform one shift step |
| carry_in | input | 1 | Bit folded into the feedback (data input when scrambling) |
| bit_out | output | 1 | State bit 0, the newest generated bit |
| word_out | output | 32 | Low 32 state bits captured at the last strobe |
| word_valid | output | 1 | One-cycle strobe when a new word is captured |

## Verification
A wrong state or tap bit does not show up right away on `word_out`. It first reaches `bit_out`, and only in the first step whose masked parity depends on that bit. The bench therefore compares `bit_out` against an independent model after every cycle, so a fault becomes visible within a few steps instead of waiting for the next word. A wrong step count appears as a strobe that comes one or more steps early or late, and the step-by-step `word_valid` comparison flags it in the cycle it happens. The fixed four-word vector then pins down the shift direction, the tap alignment and the word packing all together.

// File: rtl/pn_gen_pkg.sv
package pn_gen_pkg;
   typedef enum logic [1:0] {
      PN_HOLD = 2'd0,
      PN_STEP = 2'd1,
      PN_LOAD = 2'd2
   } pn_op_e;
endpackage

// File: rtl/pn_gen_fb.sv
module pn_gen_fb #(
   parameter int W       = 40,
   parameter int FB_TREE = 1
) (
   input  logic [W-1:0] state,
   input  logic [W-1:0] taps,
   input  logic         carry,
   output logic         fb
);
   generate
      if (FB_TREE != 0) begin : g_tree
         assign fb = (^(state & taps)) ^ carry;
      end else begin : g_chain
         logic [W:0] acc;
         assign acc[0] = carry;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign acc[i+1] = acc[i] ^ (state[i] & taps[i]);
         end
         assign fb = acc[W];
      end
   endgenerate
endmodule

// File: rtl/pn_gen_core.sv
module pn_gen_core
   import pn_gen_pkg::*;
#(
   parameter int           W        = 40,
   parameter logic [W-1:0] RST_SEED = '0,
   parameter logic [W-1:0] RST_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  pn_op_e       op,
   input  logic         seed_load,
   input  logic [W-1:0] seed_value,
   input  logic         mask_load,
   input  logic [W-1:0] mask_value,
   input  logic [W-1:0] next_state,
   output logic [W-1:0] state_q,
   output logic [W-1:0] mask_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RST_SEED;
         mask_q  <= RST_MASK;
      end else begin
         case (op)
            PN_LOAD: begin
               if (seed_load) state_q <= seed_value;
               if (mask_load) mask_q  <= mask_value;
            end
            PN_STEP: state_q <= next_state;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pn_gen_pack.sv
module pn_gen_pack
   import pn_gen_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pn_op_e            op,
   input  logic [WORD_W-1:0] next_low,
   output logic [WORD_W-1:0] word_q,
   output logic              valid_q
);
   localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         word_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         case (op)
            PN_LOAD: cnt_q <= '0;
            PN_STEP: begin
               if (cnt_q == LAST) begin
                  cnt_q   <= '0;
                  word_q  <= next_low;
                  valid_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pn_gen.sv
module pn_gen
   import pn_gen_pkg::*;
#(
   parameter int                 STATE_W  = 40,
   parameter int                 WORD_W   = 32,
   parameter int                 FB_TREE  = 1,
   parameter logic [STATE_W-1:0] RST_SEED = 40'h00_0000_0001,
   parameter logic [STATE_W-1:0] RST_MASK = 40'h8D_AB18_1CD4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seed_load,
   input  logic [STATE_W-1:0] seed_value,
   input  logic               mask_load,
   input  logic [STATE_W-1:0] mask_value,
   input  logic               step_en,
   input  logic               carry_in,
   output logic               bit_out,
   output logic [WORD_W-1:0]  word_out,
   output logic               word_valid
);
   generate
      if (STATE_W < 2) begin : g_bad_state
         $error("pn_gen: STATE_W must be at least 2");
      end
      if (WORD_W < 2 || WORD_W > STATE_W) begin : g_bad_word
         $error("pn_gen: WORD_W must lie in 2..STATE_W");
      end
   endgenerate

   pn_op_e             op;
   logic               fb;
   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] mask_q;
   logic [STATE_W-1:0] shifted;

   always_comb begin
      if (seed_load || mask_load) op = PN_LOAD;
      else if (step_en)           op = PN_STEP;
      else                        op = PN_HOLD;
   end

   pn_gen_fb #(.W(STATE_W), .FB_TREE(FB_TREE)) u_fb (
      .state (state_q),
      .taps  (mask_q),
      .carry (carry_in),
      .fb    (fb)
   );

   assign shifted = {state_q[STATE_W-2:0], fb};

   pn_gen_core #(.W(STATE_W), .RST_SEED(RST_SEED), .RST_MASK(RST_MASK)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .seed_load  (seed_load),
      .seed_value (seed_value),
      .mask_load  (mask_load),
      .mask_value (mask_value),
      .next_state (shifted),
      .state_q    (state_q),
      .mask_q     (mask_q)
   );

   pn_gen_pack #(.WORD_W(WORD_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .next_low (shifted[WORD_W-1:0]),
      .word_q   (word_out),
      .valid_q  (word_valid)
   );

   assign bit_out = state_q[0];
endmodule

// File: rtl/pn_gen_chk.sv
module pn_gen_chk #(
   parameter int STATE_W = 40,
   parameter int WORD_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               seed_load,
   input logic [STATE_W-1:0] seed_value,
   input logic               mask_load,
   input logic               step_en,
   input logic               carry_in,
   input logic               bit_out,
   input logic [WORD_W-1:0]  word_out,
   input logic               word_valid,
   input logic [STATE_W-1:0] state_q,
   input logic [STATE_W-1:0] mask_q
);
   localparam int CNT_W = $clog2(WORD_W) + 1;

   logic             any_load;
   logic             do_step;
   logic [CNT_W-1:0] steps_seen;

   assign any_load = seed_load | mask_load;
   assign do_step  = step_en & ~any_load;

   always_ff @(posedge clk) begin
      if (!rst_n)                                   steps_seen <= '0;
      else if (any_load)                            steps_seen <= '0;
      else if (do_step && steps_seen == CNT_W'(WORD_W - 1)) steps_seen <= '0;
      else if (do_step)                             steps_seen <= steps_seen + 1'b1;
   end

   // R2: feedback bit and shift direction
   assert_feedback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      do_step |=> (bit_out == $past((^(state_q & mask_q)) ^ carry_in)) &&
                  (state_q[STATE_W-1:1] == $past(state_q[STATE_W-2:0])));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !any_load) |=> ($stable(state_q) && !word_valid));

   assert_strobe_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (do_step && steps_seen == CNT_W'(WORD_W - 1)) |=> word_valid);

   assert_no_early_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (do_step && steps_seen != CNT_W'(WORD_W - 1)) |=> !word_valid);

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   assert_seed_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> (state_q == $past(seed_value)) && !word_valid);

   assert_mask_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_load && !seed_load) |=> $stable(state_q) && !word_valid);

   assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> $stable(word_out));
endmodule

bind pn_gen pn_gen_chk #(.STATE_W(STATE_W), .WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .seed_load  (seed_load),
   .seed_value (seed_value),
   .mask_load  (mask_load),
   .step_en    (step_en),
   .carry_in   (carry_in),
   .bit_out    (bit_out),
   .word_out   (word_out),
   .word_valid (word_valid),
   .state_q    (state_q),
   .mask_q     (mask_q)
);

// File: tb/pn_gen_tb.sv
`timescale 1ns/1ps
module pn_gen_tb;
   localparam logic [39:0] T_MASK = 40'h8D_AB18_1CD4;
   localparam logic [39:0] T_SEED = 40'h00_0000_0001;
   localparam logic [31:0] VEC [4] = '{32'h2FC95ADF, 32'h5520BD91,
                                       32'h7FEF80D5, 32'h915C34D1};
   localparam logic [31:0] PAT = 32'hA5C30F96;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_load = 1'b0;
   logic [39:0] seed_value = '0;
   logic        mask_load = 1'b0;
   logic [39:0] mask_value = '0;
   logic        step_en = 1'b0;
   logic        carry_in = 1'b0;
   logic        bit_out;
   logic [31:0] word_out;
   logic        word_valid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [39:0] m_state, m_mask;
   logic [31:0] m_word;
   logic        m_valid;
   int          m_cnt;

   always #2.5 clk = ~clk;

   pn_gen u_dut (
      .clk(clk), .rst_n(rst_n),
      .seed_load(seed_load), .seed_value(seed_value),
      .mask_load(mask_load), .mask_value(mask_value),
      .step_en(step_en), .carry_in(carry_in),
      .bit_out(bit_out), .word_out(word_out), .word_valid(word_valid)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, model update, compare at next negedge
   task automatic cyc(input logic ls, input logic [39:0] sv, input logic lm,
                      input logic [39:0] mv, input logic en, input logic c,
                      input string tag);
      seed_load = ls; seed_value = sv; mask_load = lm; mask_value = mv;
      step_en = en; carry_in = c;
      @(negedge clk);
      m_valid = 1'b0;
      if (ls || lm) begin
         if (ls) m_state = sv;
         if (lm) m_mask = mv;
         m_cnt = 0;
      end else if (en) begin
         m_state = {m_state[38:0], (^(m_state & m_mask)) ^ c};
         if (m_cnt == 31) begin
            m_cnt = 0; m_word = m_state[31:0]; m_valid = 1'b1;
         end else m_cnt++;
      end
      chk({tag, " bit_out"}, 64'(bit_out), 64'(m_state[0]));
      chk({tag, " word_valid"}, 64'(word_valid), 64'(m_valid));
      chk({tag, " word_out"}, 64'(word_out), 64'(m_word));
      seed_load = 1'b0; mask_load = 1'b0; step_en = 1'b0; carry_in = 1'b0;
   endtask

   task automatic step(input logic c, input string tag);
      cyc(1'b0, '0, 1'b0, '0, 1'b1, c, tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      m_state = T_SEED; m_mask = T_MASK; m_word = '0; m_valid = 1'b0; m_cnt = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset word_out", 64'(word_out), 64'h0);
      chk("R1 reset word_valid", 64'(word_valid), 64'h0);
      chk("R1 reset bit_out", 64'(bit_out), 64'h1);
      rst_n = 1'b1;

      // R5: vector table after explicit seed+mask load in one cycle (R7)
      cyc(1'b1, T_SEED, 1'b1, T_MASK, 1'b1, 1'b0, "R7 dual load");
      for (int w = 0; w < 4; w++) begin
         for (int s = 0; s < 32; s++) step(1'b0, "R4 step");
         chk("R5 vector word", 64'(word_out), 64'(VEC[w]));
         chk("R4 strobe", 64'(word_valid), 64'h1);
      end

      // R8: word held across later steps and holds
      held = word_out;
      for (int s = 0; s < 5; s++) step(1'b1, "R8 step");
      chk("R8 held", 64'(word_out), 64'(held));

      // R3: no step requested
      held = {31'b0, bit_out};
      for (int s = 0; s < 6; s++) cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, "R3 hold");
      chk("R3 stable", 64'(bit_out), 64'(held[0]));

      // R9: zero mask, carry stream lands in the word
      cyc(1'b1, 40'h0, 1'b1, 40'h0, 1'b0, 1'b0, "R9 load");
      for (int s = 31; s >= 0; s--) step(PAT[s], "R9 scramble");
      chk("R9 word", 64'(word_out), 64'(PAT));

      // R2: top bit dropped, feedback from old state
      cyc(1'b1, 40'h80_0000_0000, 1'b1, 40'h80_0000_0000, 1'b0, 1'b0, "R2 load");
      step(1'b0, "R2 top");
      chk("R2 top bit feedback", 64'(bit_out), 64'h1);
      step(1'b0, "R2 drop");
      chk("R2 top bit dropped", 64'(bit_out), 64'h0);
      cyc(1'b1, 40'h3C_5A96_0F11, 1'b1, 40'hC1_2345_6789, 1'b0, 1'b0, "R2 load2");
      for (int s = 0; s < 45; s++) step(s[0] ^ s[2], "R2 mixed");

      // R6: seed load wins over step, count restarts
      for (int s = 0; s < 10; s++) step(1'b0, "R6 pre");
      cyc(1'b1, 40'h12_3456_789B, 1'b0, '0, 1'b1, 1'b1, "R6 seed+step");
      chk("R6 seed bit0", 64'(bit_out), 64'h1);
      for (int s = 0; s < 31; s++) step(1'b0, "R6 count");
      chk("R6 no early strobe", 64'(word_valid), 64'h0);
      step(1'b0, "R6 32nd");
      chk("R6 strobe at 32", 64'(word_valid), 64'h1);

      // R7: mask load mid-word keeps state and restarts count
      for (int s = 0; s < 7; s++) step(1'b1, "R7 pre");
      held = {31'b0, bit_out};
      cyc(1'b0, '0, 1'b1, 40'h55_0F0F_F00F, 1'b1, 1'b0, "R7 mask+step");
      chk("R7 state kept", 64'(bit_out), 64'(held[0]));
      for (int s = 0; s < 32; s++) step(s[1], "R7 new mask");
      chk("R7 strobe at 32", 64'(word_valid), 64'h1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule